// File: doc/BRIEF.md
# RTC Shared Square-Wave / Alarm-Interrupt Pin Controller

This block owns the single output pin that a real-time clock shares between a square-wave clock output and an active-low alarm interrupt. It holds a small control register: a two-bit rate field, a mode bit that picks square wave or interrupt, one interrupt enable per alarm and an enable that keeps the pin driving while the chip runs from its backup battery. Every field has a defined power-on value. A binary divider runs from a one-cycle tick at the 32.768 kHz reference rate and gives four square-wave rates, each with a 50% duty cycle.

In interrupt mode the pin acts as an open-drain line. It is pulled low while any alarm flag whose enable is set is high, and it is released otherwise. The alarm flags come from outside and are set whatever the mode is. The enables decide only whether a flag reaches the pin. While the chip runs from battery, the pin is released unless the battery enable is set, in which case it behaves as it does on main power. The pin is presented as a level plus an output enable, and the pad cell forms the tri-state from these two signals.

Top module: `rtc_pin_ctrl`

## Requirements
- R1: After reset the control register reads 6'h1C. Its fields are [5] battery enable = 0, [4:3] rate = 2'b11, [2] interrupt mode = 1, [1] alarm-2 enable = 0 and [0] alarm-1 enable = 0.
- R2: The register takes `ctl_wdata` on the clock edge at which `ctl_we` is high. While `ctl_we` is low, any change on `ctl_wdata` leaves it unchanged.
- R3: The rate field sets the square-wave division of the reference tick: 2'b00 divides by 32768 (1 Hz), 2'b01 by 32 (1.024 kHz), 2'b10 by 8 (4.096 kHz) and 2'b11 by 4 (8.192 kHz). The wave is low for the first half of each period, counted from reset, and high for the second half.
- R4: The divider advances only on cycles where `ref_tick` is high. While `ref_tick` is low it holds its state.
- R5: In square-wave mode (mode bit 0), when the pin is not blocked by R8, `pin_oe` is 1 and `pin_lvl` follows the square wave.
- R6: In interrupt mode, when the pin is not blocked by R8, `pin_oe` is 1 and `pin_lvl` is 0 exactly when (flag[0] AND enable[0]) OR (flag[1] AND enable[1]). Otherwise `pin_oe` is 0.
- R7: A flag whose enable bit is 0 has no effect on the pin. In square-wave mode no flag has any effect on the pin.
- R8: With `on_battery` = 1 and the battery enable at 0, `pin_oe` is 0 in both modes.
- R9: With `on_battery` = 1 and the battery enable at 1, the pin behaves exactly as it does on main power.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| ref_tick | input | 1 | One-cycle pulse at the 32.768 kHz reference rate |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 6 | Control register write data |
| ctl_q | output | 6 | Current control register contents |
| alarm_flag | input | 2 | Alarm flags from the match logic (bit 0 = alarm 1) |
| on_battery | input | 1 | 1 while main power is absent |
| pin_oe | output | 1 | Pin output enable (0 = high impedance) |
| pin_lvl | output | 1 | Level driven while `pin_oe` is 1 |

## Verification
Every rate is run for at least a full period with a reference tick on every cycle. The bench checks each cycle against a tick count it keeps itself, which separates the four tap positions and confirms the duty split. A gapped and a stalled tick pattern tell a divider that counts ticks apart from one that counts clocks. A full cross of mode, both enables, battery enable, battery state and all four flag patterns separates correct flag gating from a missing enable, a swapped alarm index or a wrong release under battery power. Writing with the strobe low tells a held register apart from one that follows the bus.

// File: rtl/rtc_pin_pkg.sv
package rtc_pin_pkg;

  localparam int CTL_W = 6;
  localparam int N_ALM = 2;

  typedef struct packed {
    logic             bat_sq_en;
    logic [1:0]       rate;
    logic             int_mode;
    logic [N_ALM-1:0] alarm_ie;
  } ctl_t;

  localparam ctl_t CTL_RST = '{bat_sq_en: 1'b0, rate: 2'b11, int_mode: 1'b1,
                               alarm_ie: '0};

  // Counter bit whose value is the square wave for a given rate.
  // A bit k of a free counter has period 2^(k+1) ticks.
  function automatic int unsigned tap_of(input logic [1:0] rate, input int unsigned cnt_w);
    case (rate)
      2'b00:   tap_of = cnt_w - 1;  // divide by 2^cnt_w
      2'b01:   tap_of = 4;          // divide by 32
      2'b10:   tap_of = 2;          // divide by 8
      default: tap_of = 1;          // divide by 4
    endcase
  endfunction

endpackage

// File: rtl/rtc_ctl_reg.sv
module rtc_ctl_reg
  import rtc_pin_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CTL_W-1:0] wdata,
  output ctl_t             q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= CTL_RST;
    else if (we) q <= ctl_t'(wdata);
  end

endmodule

// File: rtl/rtc_sq_div.sv
module rtc_sq_div
  import rtc_pin_pkg::*;
#(
  parameter int unsigned CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [1:0]       rate,
  output logic             sq,
  output logic [CNT_W-1:0] cnt
);

  localparam int unsigned TAP_W = $clog2(CNT_W);

  logic [TAP_W-1:0] tap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= cnt + 1'b1;
  end

  always_comb begin
    tap = TAP_W'(tap_of(rate, CNT_W));
    sq  = cnt[tap];
  end

endmodule

// File: rtl/rtc_pin_sel.sv
module rtc_pin_sel
  import rtc_pin_pkg::*;
(
  input  logic             sq,
  input  ctl_t             ctl,
  input  logic [N_ALM-1:0] flags,
  input  logic             on_battery,
  output logic             irq_req,
  output logic             blocked,
  output logic             oe,
  output logic             lvl
);

  logic [N_ALM-1:0] gated;

  for (genvar i = 0; i < N_ALM; i++) begin : g_gate
    assign gated[i] = flags[i] & ctl.alarm_ie[i];
  end

  always_comb begin
    irq_req = |gated;
    blocked = on_battery & ~ctl.bat_sq_en;
    if (blocked) begin
      oe  = 1'b0;
      lvl = 1'b0;
    end else if (!ctl.int_mode) begin
      oe  = 1'b1;
      lvl = sq;
    end else begin
      oe  = irq_req;   // open drain: pull low or release
      lvl = 1'b0;
    end
  end

endmodule

// File: rtl/rtc_pin_ctrl.sv
module rtc_pin_ctrl
  import rtc_pin_pkg::*;
#(
  parameter int unsigned CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_tick,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic [CTL_W-1:0] ctl_q,
  input  logic [N_ALM-1:0] alarm_flag,
  input  logic             on_battery,
  output logic             pin_oe,
  output logic             pin_lvl
);

  ctl_t             ctl;
  logic             sq_raw;
  logic [CNT_W-1:0] div_cnt;
  logic             irq_req;
  logic             pin_blocked;

  rtc_ctl_reg u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (ctl_we),
    .wdata (ctl_wdata),
    .q     (ctl)
  );

  rtc_sq_div #(.CNT_W(CNT_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (ref_tick),
    .rate  (ctl.rate),
    .sq    (sq_raw),
    .cnt   (div_cnt)
  );

  rtc_pin_sel u_sel (
    .sq         (sq_raw),
    .ctl        (ctl),
    .flags      (alarm_flag),
    .on_battery (on_battery),
    .irq_req    (irq_req),
    .blocked    (pin_blocked),
    .oe         (pin_oe),
    .lvl        (pin_lvl)
  );

  assign ctl_q = ctl;

endmodule

// File: rtl/rtc_pin_chk.sv
module rtc_pin_chk
  import rtc_pin_pkg::*;
#(
  parameter int unsigned CNT_W = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ref_tick,
  input logic             ctl_we,
  input logic [CTL_W-1:0] ctl_q,
  input logic [N_ALM-1:0] alarm_flag,
  input logic             on_battery,
  input logic             pin_oe,
  input logic             pin_lvl,
  input logic             sq_raw,
  input logic             irq_req,
  input logic [CNT_W-1:0] div_cnt
);

  logic bat_en, int_md, blk;
  logic [N_ALM-1:0] ie;
  assign bat_en = ctl_q[5];
  assign int_md = ctl_q[2];
  assign ie     = ctl_q[1:0];
  assign blk    = on_battery & ~bat_en;

  // R2
  hold_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_we |=> $stable(ctl_q));

  // R4
  div_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_tick |=> $stable(div_cnt));

  // R5
  sq_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!blk && !int_md) |-> (pin_oe && pin_lvl == sq_raw));

  // R6
  irq_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!blk && int_md && irq_req) |-> (pin_oe && !pin_lvl));

  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_md && (alarm_flag & ie) == '0) |-> !pin_oe);

  // R8
  bat_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk |-> !pin_oe);

endmodule

bind rtc_pin_ctrl rtc_pin_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ref_tick   (ref_tick),
  .ctl_we     (ctl_we),
  .ctl_q      (ctl_q),
  .alarm_flag (alarm_flag),
  .on_battery (on_battery),
  .pin_oe     (pin_oe),
  .pin_lvl    (pin_lvl),
  .sq_raw     (sq_raw),
  .irq_req    (irq_req),
  .div_cnt    (div_cnt)
);

// File: tb/test_rtc_pin_ctrl.sv
`timescale 1ns/1ps
module test_rtc_pin_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_tick = 1'b0;
  logic       ctl_we = 1'b0;
  logic [5:0] ctl_wdata = '0;
  logic [5:0] ctl_q;
  logic [1:0] alarm_flag = '0;
  logic       on_battery = 1'b0;
  logic       pin_oe, pin_lvl;

  int unsigned ticks;
  int n_cmp = 0;
  int n_bad = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  rtc_pin_ctrl i_rtc_pin_ctrl (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .ctl_we(ctl_we),
    .ctl_wdata(ctl_wdata), .ctl_q(ctl_q), .alarm_flag(alarm_flag),
    .on_battery(on_battery), .pin_oe(pin_oe), .pin_lvl(pin_lvl)
  );

  // Independent tick count: the reference ticks seen since reset.
  always @(posedge clk or negedge rst_n)
    if (!rst_n) ticks <= 0;
    else if (ref_tick) ticks <= ticks + 1;

  // R3: divisor = 32768 / selected frequency, low half then high half.
  function automatic logic exp_sq(input logic [1:0] rate);
    int unsigned freq, div;
    case (rate)
      2'b00: freq = 1;
      2'b01: freq = 1024;
      2'b10: freq = 4096;
      default: freq = 8192;
    endcase
    div = 32768 / freq;
    return (ticks % div) >= div / 2;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [5:0] d);
    @(negedge clk);
    ctl_wdata = d;
    ctl_we = 1'b1;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic sweep_rate(input logic [1:0] r, input int cycles);
    wr({1'b0, r, 1'b0, 2'b00});
    for (int n = 0; n < cycles; n++) begin
      @(negedge clk); #1;
      chk("R3 oe", {7'd0, pin_oe}, 8'd1);
      chk("R3 lvl", {7'd0, pin_lvl}, {7'd0, exp_sq(r)});
    end
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset contents and released pin (interrupt mode, no flags)
    chk("R1 ctl", {2'b0, ctl_q}, 8'h1C);
    chk("R1 oe", {7'd0, pin_oe}, 8'd0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1 ctl after release", {2'b0, ctl_q}, 8'h1C);

    // R2: write, then bus changes with strobe low
    wr(6'h2A);
    #1 chk("R2 write", {2'b0, ctl_q}, 8'h2A);
    @(negedge clk); ctl_wdata = 6'h15;
    repeat (3) @(negedge clk);
    #1 chk("R2 hold", {2'b0, ctl_q}, 8'h2A);

    // R3 / R5: every rate, tick on every cycle
    ref_tick = 1'b1;
    sweep_rate(2'b11, 40);
    sweep_rate(2'b10, 64);
    sweep_rate(2'b01, 160);
    sweep_rate(2'b00, 33000);

    // R4: gapped then stalled tick at the fastest rate
    wr({1'b0, 2'b11, 1'b0, 2'b00});
    for (int n = 0; n < 60; n++) begin
      @(negedge clk);
      ref_tick = (n % 3 == 0);
      #1 chk("R4 gapped", {7'd0, pin_lvl}, {7'd0, exp_sq(2'b11)});
    end
    ref_tick = 1'b0;
    for (int n = 0; n < 20; n++) begin
      @(negedge clk); #1;
      chk("R4 stall", {7'd0, pin_lvl}, {7'd0, exp_sq(2'b11)});
    end
    ref_tick = 1'b1;

    // R5-R9: full cross of mode, enables, battery enable, battery, flags
    for (int md = 0; md < 2; md++)
      for (int ie = 0; ie < 4; ie++)
        for (int be = 0; be < 2; be++) begin
          wr({be[0], 2'b11, md[0], ie[1:0]});
          for (int f = 0; f < 4; f++)
            for (int ob = 0; ob < 2; ob++) begin
              logic blk, req, eoe;
              @(negedge clk);
              alarm_flag = f[1:0];
              on_battery = ob[0];
              #1;
              blk = ob[0] && !be[0];
              req = |(f[1:0] & ie[1:0]);
              if (blk) begin
                chk("R8 released", {7'd0, pin_oe}, 8'd0);
              end else begin
                eoe = md[0] ? req : 1'b1;
                if (md[0] == 0)
                  chk(ob[0] ? "R9 R5 sq" : "R5 sq", {6'd0, pin_oe, pin_lvl},
                      {6'd0, 1'b1, exp_sq(2'b11)});
                else if (req)
                  chk(ob[0] ? "R9 R6 low" : "R6 low", {6'd0, pin_oe, pin_lvl}, 8'b10);
                else
                  chk(f != 0 ? "R7 gated" : "R6 idle", {7'd0, pin_oe}, {7'd0, eoe});
              end
            end
        end

    alarm_flag = '0;
    on_battery = 1'b0;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule